// File: doc/BRIEF.md
# Wavefront Interleaving Issue Scheduler

This block picks which resident wavefront feeds a 16-lane SIMD engine on each clock cycle. A wavefront carries 64 threads, so one of its instructions is issued as four beats on four consecutive cycles, with one lane group of sixteen threads per beat. Once a wavefront's four-beat slot starts, it runs to the end. At the last beat of a slot, or on any idle cycle, the scheduler picks the next slot owner.

Each wavefront has an instruction queue outside this block. The queue shows two flags for its head instruction: one says an instruction is present, the other says it reads the result of the same wavefront's previous instruction. An ALU result can be used eight cycles after its instruction's first beat. A dependent head therefore waits until that time has passed. The scheduler meanwhile issues other eligible wavefronts round-robin, so two wavefronts that alternate can cover the whole wait. A queue advances its head when it sees the first beat of its wavefront on the outputs. Head flags are only sampled when a choice is made, so the queue has three cycles to present its next head.

Top module: `wfs_issue_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are as follows: strobe low, beat index 0, wavefront ID 0 and stall count 0. This holds whatever the head flags are.
- R2: Every launched instruction drives the strobe high on four consecutive cycles. Across those cycles the wavefront ID stays the same and the beat index steps 0, 1, 2, 3.
- R3: Head flags that change during beats 0 to 2 of a slot have no effect on that slot. They are only sampled in the last beat of a slot or in an idle cycle.
- R4: A head with its dependency flag at 1 gets its first beat no earlier than eight cycles after the first beat of the same wavefront's previous instruction. A lone dependent wavefront therefore gets four issue cycles, then four idle cycles, over and over. A head with the flag at 0 may start on the cycle right after its wavefront's previous slot ends.
- R5: Among eligible wavefronts, the next one is the first found when counting up from the most recently launched ID, wrapping from the highest ID back to 0. After reset the search begins at ID 0.
- R6: When two wavefronts both have dependent heads that are always present, they alternate four-cycle slots and no cycle is idle.
- R7: When no wavefront is eligible, the scheduler puts out an idle cycle: strobe low and beat index 0.
- R8: The stall count goes up by one for each idle cycle chosen while at least one wavefront had a head present. It does not change on issue cycles, or on idle cycles when no head is present. It saturates at its maximum.
- R9: A wavefront whose present flag is 0 is never launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wf_valid | input | NUM_WF | Bit w: wavefront w's queue has a head instruction |
| wf_dep | input | NUM_WF | Bit w: that head reads the previous result of wavefront w |
| issue_strobe | output | 1 | A lane group is issued this cycle |
| issue_quarter | output | QW (2) | Beat index 0..3 of the current slot; 0 when idle |
| issue_wf | output | IDW (3) | Wavefront ID of the current or most recent slot |
| stall_count | output | STALL_W (16) | Saturating count of idle cycles with work resident |

## Verification
The hardest case to reach from the ports is the exact end of the eight-cycle result window, which only shows when no other wavefront can fill the gap. The stimulus holds fixed head flags from reset, so every schedule is known in advance. It then checks that a single dependent wavefront is idle for cycles 4 to 7 and issues again on cycle 8. A second hard case is a head that disappears during the beats of a slot. The bench reaches it by dropping the present flag right after the first beat appears, and checks that the slot still runs to its end.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

    localparam int unsigned WFS_NUM_WF_DEF     = 8;
    localparam int unsigned WFS_WF_THREADS_DEF = 64;
    localparam int unsigned WFS_LANES_DEF      = 16;
    localparam int unsigned WFS_RESULT_LAT_DEF = 8;
    localparam int unsigned WFS_STALL_W_DEF    = 16;

    typedef enum logic {
        SLOT_IDLE  = 1'b0,
        SLOT_ISSUE = 1'b1
    } slot_e;

    // Index width for a count of n items, never below one bit.
    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Beats one instruction takes on the SIMD engine.
    function automatic int unsigned beats_per_instr(input int unsigned threads,
                                                    input int unsigned lanes);
        return (threads + lanes - 1) / lanes;
    endfunction

endpackage

// File: rtl/wfs_ready_track.sv
module wfs_ready_track
    import wfs_pkg::*;
#(
    parameter int unsigned NUM_WF     = WFS_NUM_WF_DEF,
    parameter int unsigned RESULT_LAT = WFS_RESULT_LAT_DEF,
    parameter int unsigned IDW        = id_width(WFS_NUM_WF_DEF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_WF-1:0] wf_valid,
    input  logic [NUM_WF-1:0] wf_dep,
    input  logic              launch,
    input  logic [IDW-1:0]    launch_id,
    output logic [NUM_WF-1:0] eligible
);

    localparam int unsigned CW     = id_width(RESULT_LAT);
    localparam logic [CW-1:0] LOAD = CW'(RESULT_LAT - 1);

    for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
        logic [CW-1:0] wait_q;

        // wait_q counts down the cycles left until this wavefront's last result is usable.
        always_ff @(posedge clk) begin
            if (rst) begin
                wait_q <= '0;
            end else if (launch && (launch_id == IDW'(w))) begin
                wait_q <= LOAD;
            end else if (wait_q != '0) begin
                wait_q <= wait_q - CW'(1);
            end
        end

        assign eligible[w] = wf_valid[w] && (!wf_dep[w] || (wait_q == '0));
    end

endmodule

// File: rtl/wfs_rr_pick.sv
module wfs_rr_pick
    import wfs_pkg::*;
#(
    parameter int unsigned NUM_WF = WFS_NUM_WF_DEF,
    parameter int unsigned IDW    = id_width(WFS_NUM_WF_DEF)
) (
    input  logic [NUM_WF-1:0] req,
    input  logic [IDW-1:0]    last_id,
    output logic              any,
    output logic [IDW-1:0]    pick_id
);

    logic [IDW:0] idx;

    // Search starts one past the last winner and wraps.
    always_comb begin
        any     = 1'b0;
        pick_id = '0;
        idx     = '0;
        for (int i = 1; i <= NUM_WF; i++) begin
            idx = {1'b0, last_id} + (IDW + 1)'(i);
            if (idx >= (IDW + 1)'(NUM_WF)) begin
                idx = idx - (IDW + 1)'(NUM_WF);
            end
            if (!any && req[idx[IDW-1:0]]) begin
                any     = 1'b1;
                pick_id = idx[IDW-1:0];
            end
        end
    end

endmodule

// File: rtl/wfs_slot_ctrl.sv
module wfs_slot_ctrl
    import wfs_pkg::*;
#(
    parameter int unsigned NUM_WF = WFS_NUM_WF_DEF,
    parameter int unsigned BEATS  = 4,
    parameter int unsigned IDW    = id_width(WFS_NUM_WF_DEF),
    parameter int unsigned QW     = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pick_any,
    input  logic [IDW-1:0] pick_id,
    output logic           decide,
    output logic           launch,
    output logic [IDW-1:0] last_id,
    output logic           issue_strobe,
    output logic [QW-1:0]  issue_quarter,
    output logic [IDW-1:0] issue_wf
);

    slot_e          state_q;
    logic [QW-1:0]  beat_q;
    logic [IDW-1:0] wf_q;
    logic [IDW-1:0] last_q;

    assign decide = (state_q == SLOT_IDLE) || (beat_q == QW'(BEATS - 1));
    assign launch = decide && pick_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_IDLE;
            beat_q  <= '0;
            wf_q    <= '0;
            last_q  <= IDW'(NUM_WF - 1);
        end else if (decide) begin
            beat_q <= '0;
            if (pick_any) begin
                state_q <= SLOT_ISSUE;
                wf_q    <= pick_id;
                last_q  <= pick_id;
            end else begin
                state_q <= SLOT_IDLE;
            end
        end else begin
            beat_q <= beat_q + QW'(1);
        end
    end

    assign last_id       = last_q;
    assign issue_strobe  = (state_q == SLOT_ISSUE);
    assign issue_quarter = beat_q;
    assign issue_wf      = wf_q;

endmodule

// File: rtl/wfs_stall_count.sv
module wfs_stall_count
    import wfs_pkg::*;
#(
    parameter int unsigned STALL_W = WFS_STALL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bump,
    output logic [STALL_W-1:0] count
);

    logic [STALL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != '1)) begin
            cnt_q <= cnt_q + STALL_W'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/wfs_issue_sched.sv
module wfs_issue_sched
    import wfs_pkg::*;
#(
    parameter int unsigned NUM_WF     = WFS_NUM_WF_DEF,
    parameter int unsigned WF_THREADS = WFS_WF_THREADS_DEF,
    parameter int unsigned LANES      = WFS_LANES_DEF,
    parameter int unsigned RESULT_LAT = WFS_RESULT_LAT_DEF,
    parameter int unsigned STALL_W    = WFS_STALL_W_DEF,
    parameter int unsigned IDW        = id_width(NUM_WF),
    parameter int unsigned QW         = id_width(beats_per_instr(WF_THREADS, LANES))
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_WF-1:0]  wf_valid,
    input  logic [NUM_WF-1:0]  wf_dep,
    output logic               issue_strobe,
    output logic [QW-1:0]      issue_quarter,
    output logic [IDW-1:0]     issue_wf,
    output logic [STALL_W-1:0] stall_count
);

    localparam int unsigned BEATS = beats_per_instr(WF_THREADS, LANES);

    logic [NUM_WF-1:0] eligible;
    logic              pick_any;
    logic [IDW-1:0]    pick_id;
    logic              decide;
    logic              launch;
    logic [IDW-1:0]    last_id;
    logic              idle_bump;

    wfs_ready_track #(
        .NUM_WF    (NUM_WF),
        .RESULT_LAT(RESULT_LAT),
        .IDW       (IDW)
    ) i_track (
        .clk      (clk),
        .rst      (rst),
        .wf_valid (wf_valid),
        .wf_dep   (wf_dep),
        .launch   (launch),
        .launch_id(pick_id),
        .eligible (eligible)
    );

    wfs_rr_pick #(
        .NUM_WF(NUM_WF),
        .IDW   (IDW)
    ) i_pick (
        .req    (eligible),
        .last_id(last_id),
        .any    (pick_any),
        .pick_id(pick_id)
    );

    wfs_slot_ctrl #(
        .NUM_WF(NUM_WF),
        .BEATS (BEATS),
        .IDW   (IDW),
        .QW    (QW)
    ) i_slot (
        .clk          (clk),
        .rst          (rst),
        .pick_any     (pick_any),
        .pick_id      (pick_id),
        .decide       (decide),
        .launch       (launch),
        .last_id      (last_id),
        .issue_strobe (issue_strobe),
        .issue_quarter(issue_quarter),
        .issue_wf     (issue_wf)
    );

    assign idle_bump = decide && !pick_any && (|wf_valid);

    wfs_stall_count #(
        .STALL_W(STALL_W)
    ) i_stall (
        .clk  (clk),
        .rst  (rst),
        .bump (idle_bump),
        .count(stall_count)
    );

endmodule

// File: rtl/wfs_issue_sched_chk.sv
module wfs_issue_sched_chk #(
    parameter int unsigned NUM_WF     = 8,
    parameter int unsigned RESULT_LAT = 8,
    parameter int unsigned STALL_W    = 16,
    parameter int unsigned IDW        = 3,
    parameter int unsigned QW         = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_WF-1:0]  wf_valid,
    input logic [NUM_WF-1:0]  wf_dep,
    input logic               issue_strobe,
    input logic [QW-1:0]      issue_quarter,
    input logic [IDW-1:0]     issue_wf,
    input logic [STALL_W-1:0] stall_count
);

    localparam int unsigned AW = $clog2(RESULT_LAT + 1) + 1;

    logic [NUM_WF-1:0] valid_q;
    logic [NUM_WF-1:0] dep_q;
    logic [AW-1:0]     age_q [NUM_WF];

    always_ff @(posedge clk) begin
        valid_q <= wf_valid;
        dep_q   <= wf_dep;
    end

    // Cycles since each wavefront's last observed first beat, saturating.
    for (genvar w = 0; w < NUM_WF; w++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q[w] <= AW'(RESULT_LAT);
            end else if (issue_strobe && (issue_quarter == '0) && (issue_wf == IDW'(w))) begin
                age_q[w] <= AW'(1);
            end else if (age_q[w] < AW'(RESULT_LAT)) begin
                age_q[w] <= age_q[w] + AW'(1);
            end
        end
    end

    a_r2_beat_steps: assert property (@(posedge clk) disable iff (rst)
        (issue_strobe && (issue_quarter != '1)) |=>
            (issue_strobe && (issue_quarter == $past(issue_quarter) + QW'(1))
             && (issue_wf == $past(issue_wf))));

    a_r2_slot_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(issue_strobe) |-> (issue_quarter == '0));

    a_r7_idle_beat_zero: assert property (@(posedge clk) disable iff (rst)
        !issue_strobe |-> (issue_quarter == '0));

    a_r4_dep_latency: assert property (@(posedge clk) disable iff (rst)
        (issue_strobe && (issue_quarter == '0) && dep_q[issue_wf]) |->
            (age_q[issue_wf] >= AW'(RESULT_LAT)));

    a_r9_only_present: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && issue_strobe && (issue_quarter == '0)) |-> valid_q[issue_wf]);

    a_r8_idle_counts: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !issue_strobe && (|valid_q) && ($past(stall_count) != '1)) |->
            (stall_count == $past(stall_count) + STALL_W'(1)));

    a_r8_issue_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && issue_strobe) |-> $stable(stall_count));

endmodule

bind wfs_issue_sched wfs_issue_sched_chk #(
    .NUM_WF    (NUM_WF),
    .RESULT_LAT(RESULT_LAT),
    .STALL_W   (STALL_W),
    .IDW       (IDW),
    .QW        (QW)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .wf_valid     (wf_valid),
    .wf_dep       (wf_dep),
    .issue_strobe (issue_strobe),
    .issue_quarter(issue_quarter),
    .issue_wf     (issue_wf),
    .stall_count  (stall_count)
);

// File: tb/test_wfs_issue_sched.sv
module test_wfs_issue_sched;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned WATCHDOG   = 20000;
    localparam int unsigned N_SCEN     = 9;
    localparam int unsigned N_SAMPLES  = 16;

    // Row: {present[7:0], dep[7:0], four slot codes {strobe, id[2:0]}, stall after 16 cycles}
    localparam logic [39:0] SCEN [N_SCEN] = '{
        {8'h01, 8'h00, 16'h8888, 8'd0},   // lone independent wavefront
        {8'h01, 8'h01, 16'h8080, 8'd8},   // lone dependent: 4 issue, 4 idle
        {8'h03, 8'h03, 16'h8989, 8'd0},   // two dependent wavefronts hide latency
        {8'h07, 8'h00, 16'h89A8, 8'd0},   // rotation over three
        {8'h81, 8'h81, 16'h8F8F, 8'd0},   // wrap from 7 back to 0
        {8'h0F, 8'h00, 16'h89AB, 8'd0},   // rotation over four
        {8'h00, 8'h00, 16'h0000, 8'd0},   // nothing resident
        {8'h05, 8'h05, 16'h8A8A, 8'd0},   // two dependent with gap in IDs
        {8'h02, 8'h02, 16'h9090, 8'd8}    // only wavefront 1, dependent
    };

    logic        clk;
    logic        rst;
    logic [7:0]  wf_valid;
    logic [7:0]  wf_dep;
    logic        issue_strobe;
    logic [1:0]  issue_quarter;
    logic [2:0]  issue_wf;
    logic [15:0] stall_count;

    int n_chk  = 0;
    int n_fail = 0;

    wfs_issue_sched i_wfs_issue_sched (
        .clk          (clk),
        .rst          (rst),
        .wf_valid     (wf_valid),
        .wf_dep       (wf_dep),
        .issue_strobe (issue_strobe),
        .issue_quarter(issue_quarter),
        .issue_wf     (issue_wf),
        .stall_count  (stall_count)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string strobe_tag(input int s);
        case (s)
            1, 8:    return "R4";
            2, 7:    return "R6";
            6:       return "R7";
            default: return "R2";
        endcase
    endfunction

    function automatic string id_tag(input int s);
        return (s == 8) ? "R9" : "R5";
    endfunction

    task automatic do_reset(input logic [7:0] v, input logic [7:0] d);
        rst      = 1'b1;
        wf_valid = v;
        wf_dep   = d;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d",
                 WATCHDOG, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        wf_valid = 8'hFF;
        wf_dep   = 8'h00;

        // R1: reset state holds regardless of head flags
        repeat (3) @(negedge clk);
        check("R1", "strobe in reset", 32'(issue_strobe), 32'd0);
        check("R1", "quarter in reset", 32'(issue_quarter), 32'd0);
        check("R1", "id in reset", 32'(issue_wf), 32'd0);
        check("R1", "stall in reset", 32'(stall_count), 32'd0);

        // Table walk: fixed heads from reset, expected schedule per cycle
        for (int s = 0; s < N_SCEN; s++) begin
            do_reset(SCEN[s][39:32], SCEN[s][31:24]);
            for (int k = 0; k < N_SAMPLES; k++) begin
                logic [3:0] code;
                @(negedge clk);
                code = SCEN[s][8 + 4 * (3 - k / 4) +: 4];
                check(strobe_tag(s), $sformatf("scen %0d cycle %0d strobe", s, k),
                      32'(issue_strobe), 32'(code[3]));
                check("R2", $sformatf("scen %0d cycle %0d quarter", s, k),
                      32'(issue_quarter), code[3] ? 32'(k % 4) : 32'd0);
                if (code[3]) begin
                    check(id_tag(s), $sformatf("scen %0d cycle %0d id", s, k),
                          32'(issue_wf), 32'(code[2:0]));
                end
            end
            check("R8", $sformatf("scen %0d stall count", s),
                  32'(stall_count), 32'(SCEN[s][7:0]));
        end

        // R3: head of the running wavefront vanishes after beat 0; slot completes
        do_reset(8'h03, 8'h00);
        @(negedge clk);
        check("R3", "first beat id", 32'(issue_wf), 32'd0);
        wf_valid = 8'h02;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            check("R3", $sformatf("beat %0d strobe", k), 32'(issue_strobe), 32'd1);
            check("R3", $sformatf("beat %0d id", k), 32'(issue_wf), 32'd0);
            check("R3", $sformatf("beat %0d quarter", k), 32'(issue_quarter), 32'(k));
        end
        @(negedge clk);
        check("R3", "next slot id", 32'(issue_wf), 32'd1);
        check("R3", "next slot quarter", 32'(issue_quarter), 32'd0);

        // R1/R5: reset in mid-run clears stall count and restarts the search at ID 0
        do_reset(8'h01, 8'h01);
        repeat (7) @(negedge clk);
        check("R8", "stall before mid-run reset", 32'(stall_count), 32'd3);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "stall after mid-run reset", 32'(stall_count), 32'd0);
        check("R1", "strobe after mid-run reset", 32'(issue_strobe), 32'd0);
        wf_valid = 8'h06;
        wf_dep   = 8'h00;
        rst      = 1'b0;
        @(negedge clk);
        check("R5", "first pick after reset", 32'(issue_wf), 32'd1);
        check("R5", "first pick strobe", 32'(issue_strobe), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule